// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port. Its frame format is set by three configuration inputs: 7- or 8-bit characters, a parity mode (none, forced low, forced high, even, odd) and one or two stop bits. A one-cycle write strobe loads a character and starts sending it on `txd`. A one-cycle read strobe takes the character last received on `rxd`. Transmit and receive keep separate storage. The receive side has a shift stage and a holding stage, so one character can wait to be read while the next one arrives.

Bit timing comes from an external enable, `baud_tick`, which runs at sixteen times the bit rate. The transmitter holds each line bit for 16 ticks. Its states are TX_IDLE, TX_START, TX_DATA, TX_PAR and TX_STOP, with these transitions:
- TX_IDLE→TX_START on a write.
- TX_START→TX_DATA after 16 ticks.
- TX_DATA→TX_PAR or TX_STOP after the last data bit.
- TX_PAR→TX_STOP after 16 ticks.
- TX_STOP→TX_IDLE after the last stop bit. With two stop bits, TX_STOP stays in place for one extra bit.

The receiver synchronises `rxd` through two flops. Its states are RX_IDLE, RX_START, RX_DATA, RX_PAR and RX_STOP, with these transitions:
- RX_IDLE→RX_START on a tick that sees the line low.
- RX_START→RX_DATA if the line is still low at mid-bit, 8 ticks later. Otherwise RX_START→RX_IDLE.
- RX_DATA→RX_PAR or RX_STOP after the last data bit. Each data bit is sampled 16 ticks after the previous sample.
- RX_PAR→RX_STOP after the parity sample.
- RX_STOP→RX_IDLE at the centre of the first stop bit. The character is delivered at that point.

Top module: `uart_xcvr`

## Requirements
- R1: After reset, `txd`=1, and `tx_busy`, `rx_avail`, `rx_irq`, `overrun`, `par_err` and `frm_err` are all 0.
- R2: A frame is sent as follows: a start bit (0), then the data bits with the least significant bit first, then the optional parity bit, then the stop bit(s) (1). Each bit lasts 16 `baud_tick` periods, and the line rests at 1.
- R3: `cfg_len8`=1 sends and receives 8 data bits, and `cfg_len8`=0 sends and receives 7 data bits (bits 6..0).
- R4: The `cfg_par` encoding is 3'b000 = no parity bit, 3'b100 = parity bit 0, 3'b101 = parity bit 1, 3'b110 = even (data ones plus parity bit is even), 3'b111 = odd. The codes 001 to 011 behave as no parity.
- R5: `cfg_stop2`=0 sends one stop bit and `cfg_stop2`=1 sends two. `tx_busy` stays high through the last stop bit.
- R6: A `wr_en` pulse while idle starts a transmission of `wr_data`. `tx_busy` is 1 from the cycle after the write until the last stop bit ends. A write while busy is ignored.
- R7: When a reception ends, the character moves to the holding buffer on `rd_data`, `rx_avail` becomes 1, and `rx_irq` is high for exactly one cycle.
- R8: A `rd_en` pulse clears `rx_avail`. The held value on `rd_data` is kept until the next reception ends.
- R9: If `rx_avail` is still 1 when another reception ends, `overrun` becomes 1. The flag is re-evaluated at every completed reception.
- R10: In 7-bit mode, bit 7 of a received character on `rd_data` is always 0.
- R11: A received parity bit that disagrees with the selected mode sets `par_err`. The flag holds until the next completed reception.
- R12: A 0 sampled at the centre of the first stop bit sets `frm_err`. The flag holds until the next completed reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle enable at 16x the bit rate |
| cfg_len8 | input | 1 | 1 = 8-bit characters, 0 = 7-bit |
| cfg_par | input | 3 | Parity mode (see R4) |
| cfg_stop2 | input | 1 | 1 = two stop bits |
| wr_en | input | 1 | Write strobe for the transmit buffer |
| wr_data | input | 8 | Character to send |
| rd_en | input | 1 | Read strobe for the holding buffer |
| rd_data | output | 8 | Held received character |
| rx_avail | output | 1 | Unread character present |
| rx_irq | output | 1 | One-cycle reception-end pulse |
| overrun | output | 1 | Previous character was lost |
| par_err | output | 1 | Parity error on last reception |
| frm_err | output | 1 | Framing error on last reception |
| tx_busy | output | 1 | Transmission in progress |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |

## Verification
A wrong transmit state shows on `txd` within one bit period, at 16 ticks of resolution: a bit appears out of place, is missing, or is duplicated. A wrong bit counter shows as a frame that is too short or too long, which `tx_busy` also reveals. A wrong receive state or sample point appears only when the character is delivered at the centre of the first stop bit: `rd_data` is shifted, or `par_err`/`frm_err`/`overrun` take the wrong value. The bench therefore compares every transmitted bit at its centre, and compares every delivered character and flag after the frame.

// File: rtl/uart_xcvr_pkg.sv
package uart_xcvr_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} tx_state_t;
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_state_t;

    localparam logic [2:0] PAR_LOW  = 3'b100;
    localparam logic [2:0] PAR_HIGH = 3'b101;
    localparam logic [2:0] PAR_EVEN = 3'b110;
    localparam logic [2:0] PAR_ODD  = 3'b111;

    // Parity bit for a mode, given the xor of the data bits in use
    function automatic logic par_from_ones(input logic ones, input logic [2:0] mode);
        logic p;
        case (mode)
            PAR_HIGH: p = 1'b1;
            PAR_EVEN: p = ones;
            PAR_ODD:  p = ~ones;
            default:  p = 1'b0;
        endcase
        return p;
    endfunction
endpackage

// File: rtl/uart_xcvr_tx.sv
module uart_xcvr_tx
    import uart_xcvr_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              len8,
    input  logic [2:0]        par_mode,
    input  logic              stop2,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              busy,
    output logic              txd
);
    localparam int CW = $clog2(OSR);
    localparam int BW = $clog2(DATA_W);

    tx_state_t         state, nxt;
    logic [CW-1:0]     sub;
    logic [BW-1:0]     bitn;
    logic [DATA_W-1:0] sh;
    logic              pbit, len8_q, pen_q, stop2_q, stopn;
    logic              bit_end;
    logic [BW-1:0]     last_bit;

    assign bit_end  = tick && (sub == CW'(OSR - 1));
    assign last_bit = len8_q ? BW'(DATA_W - 1) : BW'(DATA_W - 2);

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:  if (load) nxt = TX_START;
            TX_START: if (bit_end) nxt = TX_DATA;
            TX_DATA:  if (bit_end && bitn == last_bit) nxt = pen_q ? TX_PAR : TX_STOP;
            TX_PAR:   if (bit_end) nxt = TX_STOP;
            TX_STOP:  if (bit_end && (!stop2_q || stopn)) nxt = TX_IDLE;
            default:  nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub <= '0; bitn <= '0; sh <= '0; pbit <= 1'b0;
            len8_q <= 1'b1; pen_q <= 1'b0; stop2_q <= 1'b0; stopn <= 1'b0;
        end else if (state == TX_IDLE) begin
            sub <= '0; bitn <= '0; stopn <= 1'b0;
            if (load) begin
                sh      <= load_data;
                len8_q  <= len8;
                pen_q   <= par_mode[2];
                stop2_q <= stop2;
                pbit    <= par_from_ones(^(len8 ? load_data : {1'b0, load_data[DATA_W-2:0]}), par_mode);
            end
        end else begin
            if (tick) sub <= sub + 1'b1;
            if (bit_end && state == TX_DATA) begin
                sh   <= {1'b0, sh[DATA_W-1:1]};
                bitn <= bitn + 1'b1;
            end
            if (bit_end && state == TX_STOP) stopn <= 1'b1;
        end
    end

    always_comb begin
        busy = (state != TX_IDLE);
        unique case (state)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh[0];
            TX_PAR:   txd = pbit;
            default:  txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/uart_xcvr_rx.sv
module uart_xcvr_rx
    import uart_xcvr_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              len8,
    input  logic [2:0]        par_mode,
    input  logic              rxd,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              perr,
    output logic              ferr
);
    localparam int CW = $clog2(OSR);
    localparam int BW = $clog2(DATA_W);

    rx_state_t         state, nxt;
    logic [CW-1:0]     cnt;
    logic [BW-1:0]     bitn;
    logic [DATA_W-1:0] sh;
    logic              acc, perr_q, half, bit_end;
    logic [BW-1:0]     last_bit;

    assign half     = tick && (cnt == CW'(OSR / 2 - 1));
    assign bit_end  = tick && (cnt == CW'(OSR - 1));
    assign last_bit = len8 ? BW'(DATA_W - 1) : BW'(DATA_W - 2);

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:  if (tick && !rxd) nxt = RX_START;
            RX_START: if (half) nxt = rxd ? RX_IDLE : RX_DATA;
            RX_DATA:  if (bit_end && bitn == last_bit) nxt = par_mode[2] ? RX_PAR : RX_STOP;
            RX_PAR:   if (bit_end) nxt = RX_STOP;
            RX_STOP:  if (bit_end) nxt = RX_IDLE;
            default:  nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0; bitn <= '0; sh <= '0; acc <= 1'b0; perr_q <= 1'b0;
            done <= 1'b0; data <= '0; perr <= 1'b0; ferr <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == RX_IDLE || (state == RX_START && half)) cnt <= '0;
            else if (tick) cnt <= cnt + 1'b1;
            if (state == RX_IDLE) begin
                bitn <= '0; acc <= 1'b0; perr_q <= 1'b0;
            end
            if (state == RX_DATA && bit_end) begin
                sh   <= {rxd, sh[DATA_W-1:1]};
                acc  <= acc ^ rxd;
                bitn <= bitn + 1'b1;
            end
            if (state == RX_PAR && bit_end) perr_q <= (rxd != par_from_ones(acc, par_mode));
            if (state == RX_STOP && bit_end) begin
                done <= 1'b1;
                ferr <= ~rxd;
                perr <= perr_q;
                data <= len8 ? sh : {1'b0, sh[DATA_W-1:1]};
            end
        end
    end
endmodule

// File: rtl/uart_xcvr.sv
module uart_xcvr
    import uart_xcvr_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              cfg_len8,
    input  logic [2:0]        cfg_par,
    input  logic              cfg_stop2,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_avail,
    output logic              rx_irq,
    output logic              overrun,
    output logic              par_err,
    output logic              frm_err,
    output logic              tx_busy,
    output logic              txd,
    input  logic              rxd
);
    logic [1:0]        rxd_sync;
    logic              rx_done, rx_perr, rx_ferr;
    logic [DATA_W-1:0] rx_char;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rxd_sync <= 2'b11;
        else        rxd_sync <= {rxd_sync[0], rxd};
    end

    uart_xcvr_tx #(.OSR(OSR)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .len8(cfg_len8),
        .par_mode(cfg_par), .stop2(cfg_stop2), .load(wr_en),
        .load_data(wr_data), .busy(tx_busy), .txd(txd)
    );

    uart_xcvr_rx #(.OSR(OSR)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .len8(cfg_len8),
        .par_mode(cfg_par), .rxd(rxd_sync[1]), .done(rx_done),
        .data(rx_char), .perr(rx_perr), .ferr(rx_ferr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0; rx_avail <= 1'b0; rx_irq <= 1'b0;
            overrun <= 1'b0; par_err <= 1'b0; frm_err <= 1'b0;
        end else begin
            rx_irq <= rx_done;
            if (rx_done) begin
                rd_data  <= rx_char;
                rx_avail <= 1'b1;
                overrun  <= rx_avail & ~rd_en;
                par_err  <= rx_perr;
                frm_err  <= rx_ferr;
            end else if (rd_en) begin
                rx_avail <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/uart_xcvr_chk.sv
module uart_xcvr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic       cfg_len8,
    input logic [7:0] rd_data,
    input logic       rx_avail,
    input logic       rx_irq,
    input logic       overrun,
    input logic       tx_busy,
    input logic       txd
);
    // R2
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);
    // R6
    busy_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> $past(wr_en));
    // R7
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);
    // R7
    irq_with_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_avail);
    // R8
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rx_avail) |=> (!rx_avail || rx_irq));
    // R8
    held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_irq |-> $stable(rd_data));
    // R9
    overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && overrun) |-> $past(rx_avail));
    // R10
    top_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && !cfg_len8 && $stable(cfg_len8)) |-> !rd_data[7]);
endmodule

bind uart_xcvr uart_xcvr_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .cfg_len8(cfg_len8),
    .rd_data(rd_data), .rx_avail(rx_avail), .rx_irq(rx_irq), .overrun(overrun),
    .tx_busy(tx_busy), .txd(txd)
);

// File: tb/uart_xcvr_bench.sv
module uart_xcvr_bench;
    logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0;
    logic cfg_len8 = 1'b1, cfg_stop2 = 1'b0;
    logic [2:0] cfg_par = 3'b000;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic rx_avail, rx_irq, overrun, par_err, frm_err, tx_busy, txd;
    logic loop_en = 1'b1, rxd_drv = 1'b1;
    logic rxd;
    int n_chk = 0, n_fail = 0, irq_cnt = 0, irq_wide = 0, cyc = 0;
    logic irq_prev = 1'b0;
    logic div = 1'b0;

    assign rxd = loop_en ? txd : rxd_drv;

    always #2 clk = ~clk;

    always_ff @(posedge clk) begin
        div       <= ~div;
        baud_tick <= div;
        irq_prev  <= rx_irq;
        if (rx_irq) irq_cnt <= irq_cnt + 1;
        if (rx_irq && irq_prev) irq_wide <= irq_wide + 1;
        cyc <= cyc + 1;
    end

    uart_xcvr u_uart_xcvr (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .cfg_len8(cfg_len8),
        .cfg_par(cfg_par), .cfg_stop2(cfg_stop2), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rx_avail(rx_avail), .rx_irq(rx_irq),
        .overrun(overrun), .par_err(par_err), .frm_err(frm_err), .tx_busy(tx_busy),
        .txd(txd), .rxd(rxd)
    );

    function automatic logic exp_par(input logic [7:0] d, input logic len8, input logic [2:0] p);
        logic ones;
        ones = ^(d & (len8 ? 8'hFF : 8'h7F));
        if (p == 3'b101) return 1'b1;
        if (p == 3'b110) return ones;
        if (p == 3'b111) return ~ones;
        return 1'b0;
    endfunction

    function automatic int frame_len(input logic len8, input logic [2:0] p, input logic s2);
        return 1 + (len8 ? 8 : 7) + (p[2] ? 1 : 0) + (s2 ? 2 : 1);
    endfunction

    function automatic logic exp_bit(input logic [7:0] d, input logic len8, input logic [2:0] p, input int i);
        int nd;
        nd = len8 ? 8 : 7;
        if (i == 0) return 1'b0;
        if (i <= nd) return d[i-1];
        if (p[2] && i == nd + 1) return exp_par(d, len8, p);
        return 1'b1;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        int c;
        c = 0;
        while (c < n) begin
            @(negedge clk);
            if (baud_tick) c++;
        end
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic do_read();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic set_cfg(input logic len8, input logic [2:0] p, input logic s2);
        @(negedge clk); cfg_len8 = len8; cfg_par = p; cfg_stop2 = s2;
    endtask

    // Sends one frame and compares every bit at its centre (R2..R6)
    task automatic tx_frame(input logic [7:0] d, input logic [7:0] extra, input bit poke);
        int nb, bad;
        logic [15:0] got, want;
        nb = frame_len(cfg_len8, cfg_par, cfg_stop2);
        bad = 0; got = '0; want = '0;
        do_write(d);
        for (int i = 0; i < nb; i++) begin
            wait_ticks(i == 0 ? 8 : 16);
            got[i] = txd;
            want[i] = exp_bit(d, cfg_len8, cfg_par, i);
            if (txd !== want[i]) bad++;
            if (poke && i == 2) do_write(extra);
        end
        chk(bad == 0, "R2 R3 R4 frame bits", 32'(got), 32'(want));
        chk(tx_busy === 1'b1, "R5 busy during last stop bit", 32'(tx_busy), 1);
        wait_ticks(12);
        chk(tx_busy === 1'b0, "R6 busy ends after stop", 32'(tx_busy), 0);
    endtask

    task automatic rx_frame(input logic [7:0] d, input bit flip_par, input bit bad_stop);
        int nb, nd;
        logic b;
        loop_en = 1'b0;
        nb = frame_len(cfg_len8, cfg_par, cfg_stop2);
        nd = cfg_len8 ? 8 : 7;
        for (int i = 0; i < nb; i++) begin
            b = exp_bit(d, cfg_len8, cfg_par, i);
            if (flip_par && cfg_par[2] && i == nd + 1) b = ~b;
            if (bad_stop && i == nb - (cfg_stop2 ? 2 : 1)) begin
                rxd_drv = 1'b0; wait_ticks(11);
                rxd_drv = 1'b1; wait_ticks(5);
            end else begin
                rxd_drv = b; wait_ticks(16);
            end
        end
        rxd_drv = 1'b1;
        wait_ticks(4);
    endtask

    task automatic check_rx(input logic [7:0] exp_d, input int irq_before, input logic pe, input logic fe, input logic ov);
        chk(rx_avail === 1'b1, "R7 rx_avail set", 32'(rx_avail), 1);
        chk(irq_cnt == irq_before + 1, "R7 one irq per frame", irq_cnt, irq_before + 1);
        chk(rd_data === exp_d, "R3 R10 received char", 32'(rd_data), 32'(exp_d));
        chk(par_err === pe, "R11 parity flag", 32'(par_err), 32'(pe));
        chk(frm_err === fe, "R12 framing flag", 32'(frm_err), 32'(fe));
        chk(overrun === ov, "R9 overrun flag", 32'(overrun), 32'(ov));
    endtask

    initial begin : watchdog
        wait (cyc > 150000);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        int ib;
        logic [7:0] d;
        logic [2:0] pm [5];
        pm[0] = 3'b000; pm[1] = 3'b100; pm[2] = 3'b101; pm[3] = 3'b110; pm[4] = 3'b111;
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(txd === 1'b1 && tx_busy === 1'b0, "R1 tx idle", {txd, tx_busy}, 2'b10);
        chk({rx_avail, rx_irq, overrun, par_err, frm_err} === 5'b0, "R1 rx flags",
            {rx_avail, rx_irq, overrun, par_err, frm_err}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R2 R7 R8 8N1 loopback
        set_cfg(1'b1, 3'b000, 1'b0);
        ib = irq_cnt;
        tx_frame(8'hA5, 8'h00, 1'b0);
        check_rx(8'hA5, ib, 1'b0, 1'b0, 1'b0);
        do_read();
        chk(rx_avail === 1'b0, "R8 read clears avail", 32'(rx_avail), 0);
        chk(rd_data === 8'hA5, "R8 held value kept", 32'(rd_data), 32'hA5);

        // R3 R5 R10 7-bit even parity two stops, bit 7 set on write
        set_cfg(1'b0, 3'b110, 1'b1);
        ib = irq_cnt;
        tx_frame(8'hFF, 8'h00, 1'b0);
        check_rx(8'h7F, ib, 1'b0, 1'b0, 1'b0);
        do_read();

        // R4 every parity mode, incl. reserved code 3'b010 acting as none
        for (int m = 0; m < 5; m++) begin
            set_cfg(1'b1, pm[m], 1'b0);
            ib = irq_cnt;
            tx_frame(8'h6B, 8'h00, 1'b0);
            check_rx(8'h6B, ib, 1'b0, 1'b0, 1'b0);
            do_read();
        end
        set_cfg(1'b1, 3'b010, 1'b0);
        ib = irq_cnt;
        tx_frame(8'h31, 8'h00, 1'b0);
        check_rx(8'h31, ib, 1'b0, 1'b0, 1'b0);
        do_read();

        // R6 write while busy ignored
        set_cfg(1'b1, 3'b000, 1'b0);
        ib = irq_cnt;
        tx_frame(8'h3C, 8'hC3, 1'b1);
        check_rx(8'h3C, ib, 1'b0, 1'b0, 1'b0);
        do_read();
        wait_ticks(200);
        chk(irq_cnt == ib + 1 && txd === 1'b1, "R6 second write ignored", irq_cnt, ib + 1);

        // R11 parity error then cleared by a good frame
        set_cfg(1'b1, 3'b111, 1'b0);
        ib = irq_cnt;
        rx_frame(8'h5A, 1'b1, 1'b0);
        check_rx(8'h5A, ib, 1'b1, 1'b0, 1'b0);
        do_read();
        ib = irq_cnt;
        rx_frame(8'h5A, 1'b0, 1'b0);
        check_rx(8'h5A, ib, 1'b0, 1'b0, 1'b0);
        do_read();

        // R12 framing error
        set_cfg(1'b1, 3'b000, 1'b0);
        ib = irq_cnt;
        rx_frame(8'h81, 1'b0, 1'b1);
        check_rx(8'h81, ib, 1'b0, 1'b1, 1'b0);
        do_read();
        wait_ticks(40);

        // R9 overrun on unread character, cleared after read
        ib = irq_cnt;
        rx_frame(8'h11, 1'b0, 1'b0);
        rx_frame(8'h22, 1'b0, 1'b0);
        check_rx(8'h22, ib + 1, 1'b0, 1'b0, 1'b1);
        do_read();
        ib = irq_cnt;
        rx_frame(8'h33, 1'b0, 1'b0);
        check_rx(8'h33, ib, 1'b0, 1'b0, 1'b0);
        do_read();
        loop_en = 1'b1;

        // random loopback frames
        for (int k = 0; k < 30; k++) begin
            d = 8'($urandom);
            set_cfg(1'($urandom), pm[$urandom % 5], 1'($urandom));
            ib = irq_cnt;
            tx_frame(d, 8'h00, 1'b0);
            check_rx(cfg_len8 ? d : (d & 8'h7F), ib, 1'b0, 1'b0, 1'b0);
            do_read();
            chk(rx_avail === 1'b0, "R8 random read clears", 32'(rx_avail), 0);
        end

        // R7 irq never wider than one cycle
        chk(irq_wide == 0, "R7 irq one cycle", irq_wide, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule